// File: doc/BRIEF.md
# Chainable Mode-Programmable Timer

A parameterized timer counter whose operating mode comes from a 2-bit field: one-shot, periodic or event-capture, with one code value left unused. The count runs down from a programmed interval value or up from zero to it. Each time-out gives a one-cycle pulse, which also goes out as a trigger to the next timer in a chain. Each time-out also sets a sticky flag. A second sticky flag records the count reaching a programmed match value.

Timers can be chained. With wait-on-trigger selected, an enabled timer holds its count until the previous timer in the chain sends its trigger pulse. In periodic mode the timer can snapshot a sibling timer's free-running count: at every time-out it latches that value and shows it on its readable count output in place of its own counter.

Top module: `cfg_timer`

## Requirements
- R1: After synchronous reset, `count` is 0 and `timeout`, `trig_out`, `to_flag` and `match_flag` are 0.
- R2: `mode` encoding: 0 = unused (the counter never steps and no time-out occurs), 1 = one-shot, 2 = periodic, 3 = capture.
- R3: With `count_up`=0 and `en` low, the count holds `load_val`. Each step decrements it. A step taken at count 0 is a time-out and reloads `load_val`, so in periodic mode time-outs recur every `load_val`+1 steps.
- R4: With `count_up`=1, the count starts from 0 and increments on each step. A step taken at count `load_val` is a time-out and returns the count to 0.
- R5: In one-shot mode, after its time-out the timer takes no further steps until `en` is dropped. The count stays at 0 when counting down, or at `load_val` when counting up.
- R6: With `wait_trig`=1, an enabled timer holds its count until a cycle in which `trig_in` is high. It steps in that cycle and keeps counting afterwards without further triggers. With `wait_trig`=0 it steps in its first enabled cycle.
- R7: `timeout` and `trig_out` are registered one-cycle pulses. They are high in the cycle after the edge at which the time-out step is taken.
- R8: `match_flag` is set when `match_ie`=1, `mode` is 1 or 2, and a step makes the count equal `match_val`. It is never set in capture mode or with `match_ie`=0.
- R9: `to_flag` is set by each time-out and `match_flag` by each match. Both stay set until a one-cycle strobe on `clr_to` or `clr_match` respectively, and a set in the same cycle wins over the clear.
- R10: With `snap_en`=1 in periodic mode, `count` shows the value of `sib_count` latched at the last time-out edge, and holds it between time-outs.
- R11: In capture mode the counter steps only in cycles where `cap_in` is high, with the same time-out and reload rules as periodic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer enable; low holds the start value and rearms |
| trig_in | input | 1 | Trigger from the previous timer in the chain |
| cap_in | input | 1 | Event input for capture mode, one step per high cycle |
| sib_count | input | W | Sibling timer's free-running count, for snapshot |
| load_val | input | W | Interval value |
| match_val | input | W | Match compare value |
| mode | input | 2 | Operating mode (see R2) |
| count_up | input | 1 | 1 counts up, 0 counts down |
| match_ie | input | 1 | Match flag enable |
| wait_trig | input | 1 | Hold until `trig_in` before counting |
| snap_en | input | 1 | Snapshot sibling count at time-out (periodic only) |
| clr_to | input | 1 | Write-one-to-clear strobe for `to_flag` |
| clr_match | input | 1 | Write-one-to-clear strobe for `match_flag` |
| count | output | W | Readable count, or the snapshot value |
| timeout | output | 1 | One-cycle time-out pulse |
| trig_out | output | 1 | Trigger to the next timer in the chain |
| to_flag | output | 1 | Sticky time-out flag |
| match_flag | output | 1 | Sticky match flag |

## Verification
The bench sweeps interval values from 0 upward in both directions. It checks that the first and second time-outs land exactly `load_val`+1 steps apart. An off-by-one in the limit compare would shift them by a cycle, and a zero interval that never times out would show no pulse at all. One-shot runs look for a second time-out that a design which forgot to clear its run state would produce. A wait-on-trigger run confirms the count is frozen before the trigger and keeps moving after the trigger falls. A capture run spaces its events apart, so a design that counted clock cycles instead of events would time out too early. The snapshot run changes the sibling value between time-outs, which exposes a design that tracks the sibling live instead of latching it.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    MODE_UNUSED   = 2'd0,
    MODE_ONESHOT  = 2'd1,
    MODE_PERIODIC = 2'd2,
    MODE_CAPTURE  = 2'd3
  } tmode_e;

  localparam int unsigned FLAG_TO    = 0;
  localparam int unsigned FLAG_MATCH = 1;
  localparam int unsigned NUM_FLAGS  = 2;
endpackage

// File: rtl/timer_gate.sv
module timer_gate
  import timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   wait_trig,
  input  logic   trig_in,
  input  tmode_e mode,
  input  logic   stop_req,
  output logic   go
);
  logic armed_q;
  logic done_q;
  logic start_ok;

  // counting is allowed once armed, or straight away when no trigger is needed
  assign start_ok = armed_q || !wait_trig || trig_in;
  assign go       = en && !done_q && (mode != MODE_UNUSED) && start_ok;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (go)       armed_q <= 1'b1;
      if (stop_req) done_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         go,
  input  logic         cap_in,
  input  tmode_e       mode,
  input  logic         count_up,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] match_val,
  output logic [W-1:0] cnt,
  output logic         hit,
  output logic         match_hit,
  output logic         to_pulse
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic         step;
  logic         at_limit;
  logic [W-1:0] start_val;
  logic [W-1:0] nxt;

  assign step      = go && ((mode != MODE_CAPTURE) || cap_in);
  assign start_val = count_up ? ZERO : load_val;
  assign at_limit  = count_up ? (cnt == load_val) : (cnt == ZERO);

  always_comb begin
    if (!at_limit)
      nxt = count_up ? (cnt + ONE) : (cnt - ONE);
    else if (mode == MODE_ONESHOT)
      nxt = cnt;
    else
      nxt = start_val;
  end

  assign hit       = step && at_limit;
  assign match_hit = step && (nxt == match_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= ZERO;
      to_pulse <= 1'b0;
    end else begin
      to_pulse <= hit;
      if (!en)       cnt <= start_val;
      else if (step) cnt <= nxt;
    end
  end
endmodule

// File: rtl/timer_flags.sv
module timer_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
  import timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         trig_in,
  input  logic         cap_in,
  input  logic [W-1:0] sib_count,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] match_val,
  input  logic [1:0]   mode,
  input  logic         count_up,
  input  logic         match_ie,
  input  logic         wait_trig,
  input  logic         snap_en,
  input  logic         clr_to,
  input  logic         clr_match,
  output logic [W-1:0] count,
  output logic         timeout,
  output logic         trig_out,
  output logic         to_flag,
  output logic         match_flag
);
  tmode_e               mode_e;
  logic                 go;
  logic                 hit;
  logic                 match_hit;
  logic                 to_pulse;
  logic [W-1:0]         cnt;
  logic [W-1:0]         snap_q;
  logic                 snap_mode;
  logic                 match_mode;
  logic [NUM_FLAGS-1:0] fset;
  logic [NUM_FLAGS-1:0] fclr;
  logic [NUM_FLAGS-1:0] fval;

  assign mode_e     = tmode_e'(mode);
  assign snap_mode  = snap_en && (mode_e == MODE_PERIODIC);
  assign match_mode = (mode_e == MODE_ONESHOT) || (mode_e == MODE_PERIODIC);

  timer_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .wait_trig (wait_trig),
    .trig_in   (trig_in),
    .mode      (mode_e),
    .stop_req  (hit && (mode_e == MODE_ONESHOT)),
    .go        (go)
  );

  timer_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .go        (go),
    .cap_in    (cap_in),
    .mode      (mode_e),
    .count_up  (count_up),
    .load_val  (load_val),
    .match_val (match_val),
    .cnt       (cnt),
    .hit       (hit),
    .match_hit (match_hit),
    .to_pulse  (to_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)                    snap_q <= '0;
    else if (hit && snap_mode)  snap_q <= sib_count;
  end

  assign fset[FLAG_TO]    = hit;
  assign fset[FLAG_MATCH] = match_hit && match_ie && match_mode;
  assign fclr[FLAG_TO]    = clr_to;
  assign fclr[FLAG_MATCH] = clr_match;

  timer_flags #(.N(NUM_FLAGS)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .set  (fset),
    .clr  (fclr),
    .flag (fval)
  );

  assign count      = snap_mode ? snap_q : cnt;
  assign timeout    = to_pulse;
  assign trig_out   = to_pulse;
  assign to_flag    = fval[FLAG_TO];
  assign match_flag = fval[FLAG_MATCH];
endmodule

// File: rtl/cfg_timer_chk.sv
module cfg_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [1:0]   mode,
  input logic         match_ie,
  input logic         clr_to,
  input logic         timeout,
  input logic         to_flag,
  input logic         match_flag
);
  // R5
  oneshot_single_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout && mode == 2'd1 && en) |=> !timeout);

  // R9
  to_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> to_flag);

  // R9
  to_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (to_flag && !clr_to) |=> to_flag);

  // R2
  unused_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> !timeout);

  // R8
  match_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(match_flag) |-> $past(match_ie));
endmodule

bind cfg_timer cfg_timer_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .mode       (mode),
  .match_ie   (match_ie),
  .clr_to     (clr_to),
  .timeout    (timeout),
  .to_flag    (to_flag),
  .match_flag (match_flag)
);

// File: tb/cfg_timer_bench.sv
module cfg_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, trig_in = 0, cap_in = 0, count_up = 0, match_ie = 0;
  logic wait_trig = 0, snap_en = 0, clr_to = 0, clr_match = 0;
  logic [W-1:0] sib_count = '0, load_val = '0, match_val = '0;
  logic [1:0]   mode = 2'd2;
  logic [W-1:0] count;
  logic timeout, trig_out, to_flag, match_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_timer #(.W(W)) u_cfg_timer (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drop enable, program, clear flags, then enable from the next edge
  task automatic restart(logic [1:0] m, logic up, int l);
    @(negedge clk);
    en = 0; mode = m; count_up = up; load_val = W'(l);
    clr_to = 1; clr_match = 1;
    @(negedge clk);
    clr_to = 0; clr_match = 0; en = 1;
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  // first and second time-out edges after enable
  task automatic measure(int limit, output int t1, output int t2, output int n);
    t1 = -1; t2 = -1; n = 0;
    for (int e = 1; e <= limit; e++) begin
      edge_sample();
      if (timeout) begin
        n++;
        if (t1 < 0) t1 = e; else if (t2 < 0) t2 = e;
        if (trig_out !== 1'b1) check("R7 trig_out with timeout", 0, 1);
      end
    end
  endtask

  initial begin
    int t1, t2, n;
    int lv[7] = '{0, 1, 2, 3, 5, 8, 13};
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", int'(count), 0);
    check("R1 timeout", int'(timeout), 0);
    check("R1 flags", int'({to_flag, match_flag}), 0);
    @(negedge clk); rst = 0;

    // R3 / R4 sweep over periodic intervals, both directions
    for (int d = 0; d < 2; d++) begin
      foreach (lv[i]) begin
        restart(2'd2, logic'(d), lv[i]);
        measure(2 * lv[i] + 3, t1, t2, n);
        check(d ? "R4 first time-out" : "R3 first time-out", t1, lv[i] + 1);
        check(d ? "R4 period" : "R3 period", t2, 2 * (lv[i] + 1));
        check("R9 to_flag sticky", int'(to_flag), 1);
      end
    end

    // R3 / R4 count values
    restart(2'd2, 1'b0, 10);
    edge_sample(); edge_sample(); edge_sample();
    check("R3 down count", int'(count), 7);
    restart(2'd2, 1'b1, 10);
    edge_sample(); edge_sample();
    check("R4 up count from 0", int'(count), 2);

    // R5 one-shot
    for (int d = 0; d < 2; d++) begin
      restart(2'd1, logic'(d), 4);
      measure(15, t1, t2, n);
      check("R5 one time-out", n, 1);
      check("R5 first time-out", t1, 5);
      check("R5 held count", int'(count), d ? 4 : 0);
    end

    // R9 clear strobe
    @(negedge clk); en = 0; clr_to = 1;
    @(negedge clk); clr_to = 0; #1;
    check("R9 to_flag cleared", int'(to_flag), 0);

    // R2 unused mode
    restart(2'd0, 1'b0, 6);
    measure(12, t1, t2, n);
    check("R2 unused no time-out", n, 0);
    check("R2 unused count held", int'(count), 6);

    // R6 wait on trigger
    @(negedge clk); en = 0; wait_trig = 1;
    restart(2'd2, 1'b0, 9);
    repeat (6) edge_sample();
    check("R6 held before trigger", int'(count), 9);
    @(negedge clk); trig_in = 1;
    edge_sample();
    check("R6 step on trigger", int'(count), 8);
    @(negedge clk); trig_in = 0;
    edge_sample();
    check("R6 continues after trigger", int'(count), 7);
    @(negedge clk); en = 0; wait_trig = 0;

    // R8 match flag
    match_val = 8'd4; match_ie = 1;
    restart(2'd2, 1'b0, 9);
    repeat (4) edge_sample();
    check("R8 no match yet", int'(match_flag), 0);
    edge_sample();
    check("R8 match set", int'(match_flag), 1);
    repeat (3) edge_sample();
    check("R9 match sticky", int'(match_flag), 1);
    match_ie = 0;
    restart(2'd2, 1'b0, 9);
    repeat (12) edge_sample();
    check("R8 disabled no match", int'(match_flag), 0);
    match_ie = 1;
    restart(2'd3, 1'b0, 9);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); cap_in = 1;
      @(negedge clk); cap_in = 0;
    end
    #1;
    check("R8 no match in capture", int'(match_flag), 0);
    match_ie = 0;

    // R11 capture counts events only
    restart(2'd3, 1'b0, 3);
    n = 0; t1 = -1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk); cap_in = 1;
      edge_sample();
      if (timeout && t1 < 0) t1 = k;
      @(negedge clk); cap_in = 0;
      edge_sample();
      if (timeout) n++;
    end
    check("R11 time-out on 4th event", t1, 4);
    check("R11 no time-out between events", n, 0);

    // R10 snapshot
    snap_en = 1; sib_count = 8'h5A;
    restart(2'd2, 1'b0, 4);
    repeat (5) edge_sample();
    check("R10 snapshot latched", int'(count), 8'h5A);
    @(negedge clk); sib_count = 8'h33;
    repeat (4) edge_sample();
    check("R10 snapshot held", int'(count), 8'h5A);
    edge_sample();
    check("R10 snapshot updated", int'(count), 8'h33);
    snap_en = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule